// File: doc/BRIEF.md
# Buffered Character Port Interrupt Logic

This block is the register and interrupt front end of a buffered character port. Characters arriving from the far side of the link enter a receive queue through a valid/ready stream. Characters written by the processor go into a transmit queue and leave through a second valid/ready stream. The processor reaches both queues through two 32-bit words: a data word and a control word.

Interrupts follow queue levels rather than single characters. A receive interrupt is pending while more than a threshold number of characters wait to be read. A transmit interrupt is pending while more than the threshold number of slots are free. Each source has its own enable. The processor clears a pending source only by moving data: it reads characters out, or it writes characters in. Nothing acknowledges an interrupt directly.

Top module: `char_port_irq`

## Requirements
- R1: After reset both queues are empty, both enables are 0, `irq_o` is low, and the control word reports a free space of 64.
- R2: A receive character is accepted on a clock edge where `rx_valid_i` and `rx_ready_o` are both high. `rx_ready_o` is low while the receive queue holds 64 characters, so no further character is taken.
- R3: A read of the data word (`addr_i`=0) returns the oldest received character in bits 7:0, a 1 in bit 15, and in bits 31:16 the receive occupancy at the time of the access, this character included. It then removes that character. Characters come out in arrival order.
- R4: A data-word read while the receive queue is empty returns 0 in bit 15 and 0 in bits 31:16, and it changes nothing.
- R5: A write of the data word pushes `wdata_i[7:0]` into the transmit queue. `tx_valid_o` is high while that queue is non-empty, and characters leave on `tx_data_o` in write order.
- R6: A data-word write while the transmit free space is 0 is discarded.
- R7: A write of the control word (`addr_i`=1) loads the receive enable from bit 0 and the transmit enable from bit 1. A control read returns the receive enable in bit 0, the transmit enable in bit 1, receive pending in bit 8, transmit pending in bit 9 and the transmit free space in bits 31:16. All other bits read 0.
- R8: Receive pending equals the receive enable AND (occupancy > 7). It follows the occupancy in the same cycle, so it falls as soon as reads bring the occupancy to 7.
- R9: Transmit pending equals the transmit enable AND (free space > 7). It falls once writes bring the free space to 7.
- R10: `irq_o` is the OR of the two pending flags. It stays low whenever both enables are 0, whatever the queue levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = data word, 1 = control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed word, valid in the access cycle |
| irq_o | output | 1 | Interrupt to the processor |
| rx_valid_i | input | 1 | Receive character valid |
| rx_data_i | input | 8 | Receive character |
| rx_ready_o | output | 1 | Receive queue can accept |
| tx_valid_o | output | 1 | Transmit character available |
| tx_data_o | output | 8 | Transmit character |
| tx_ready_i | input | 1 | Far side takes the transmit character |

## Verification
The bench brings the receive occupancy from 7 to 8 and back, and the transmit free space from 8 to 7. A design that compares with >= instead of > would raise the interrupt one character early, and a registered pending flag would clear one cycle late. It reads the data word while the receive queue is empty: a design that pops anyway would corrupt the pointers and return stale data later. It also overfills both queues. A receive queue that takes a 65th character, or a transmit queue that takes a write at zero free space, would let the extra character show up in the drained order. Finally it checks that `irq_o` stays low with both enables off while the levels are past the threshold. A design that drives the interrupt from the raw comparison alone would fail that check.

// File: rtl/char_port_pkg.sv
package char_port_pkg;
  localparam int unsigned CHAR_W      = 8;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned FIELD_LSB   = 16;
  localparam int unsigned FIELD_W     = WORD_W - FIELD_LSB;
  localparam int unsigned VALID_BIT   = 15;
  localparam int unsigned RX_EN_BIT   = 0;
  localparam int unsigned TX_EN_BIT   = 1;
  localparam int unsigned RX_PEND_BIT = 8;
  localparam int unsigned TX_PEND_BIT = 9;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/char_irq_gen.sv
module char_irq_gen #(
  parameter int unsigned CW     = 7,
  parameter int unsigned THRESH = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_we_i,
  input  logic [1:0]    en_wdata_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_free_i,
  output logic          rx_en_o,
  output logic          tx_en_o,
  output logic          rx_pend_o,
  output logic          tx_pend_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] Thr = CW'(THRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o <= 1'b0;
      tx_en_o <= 1'b0;
    end else if (en_we_i) begin
      rx_en_o <= en_wdata_i[0];
      tx_en_o <= en_wdata_i[1];
    end
  end

  // level based: drops in the same cycle the level crosses back
  assign rx_pend_o = rx_en_o && (rx_count_i > Thr);
  assign tx_pend_o = tx_en_o && (tx_free_i > Thr);
  assign irq_o     = rx_pend_o || tx_pend_o;
endmodule

// File: rtl/char_port_irq_chk.sv
module char_port_irq_chk #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CW     = 7,
  parameter int unsigned THRESH = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          addr_i,
  input logic [31:0]   rdata_o,
  input logic          irq_o,
  input logic          rx_valid_i,
  input logic          rx_ready_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_free,
  input logic          rx_en,
  input logic          tx_en
);
  localparam logic [CW-1:0] Thr  = CW'(THRESH);
  localparam logic [CW-1:0] Full = CW'(DEPTH);

  logic rd_data, wr_data;
  assign rd_data = req_i && !we_i && (addr_i == 1'b0);
  assign wr_data = req_i && we_i && (addr_i == 1'b0);

  // R2
  rx_full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count == Full) |-> !rx_ready_o);

  // R2
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= Full);

  // R3
  rx_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && rx_count != '0 && !(rx_valid_i && rx_ready_o))
      |=> rx_count == $past(rx_count) - CW'(1));

  // R4
  rx_empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && rx_count == '0) |-> (!rdata_o[15] && rdata_o[31:16] == '0));

  // R6
  tx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && tx_free == '0 && !(tx_valid_o && tx_ready_i)) |=> tx_free == '0);

  // R8
  irq_quiet_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count <= Thr && tx_free <= Thr) |-> !irq_o);

  // R10
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en && !tx_en) |-> !irq_o);
endmodule

// File: rtl/char_port_irq.sv
module char_port_irq
  import char_port_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned THRESH = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [CW-1:0]     rx_count, tx_count, tx_free;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic [CHAR_W-1:0] rx_head;
  logic              rd_data, wr_data, wr_ctrl;
  logic              rx_en, tx_en, rx_pend, tx_pend;

  assign rd_data = req_i && !we_i && (reg_sel_e'(addr_i) == REG_DATA);
  assign wr_data = req_i && we_i  && (reg_sel_e'(addr_i) == REG_DATA);
  assign wr_ctrl = req_i && we_i  && (reg_sel_e'(addr_i) == REG_CTRL);

  char_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .pop_i   (rd_data),
    .data_o  (rx_head),
    .count_o (rx_count),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );
  assign rx_ready_o = !rx_full;

  char_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_data),
    .data_i  (wdata_i[CHAR_W-1:0]),
    .pop_i   (tx_ready_i),
    .data_o  (tx_data_o),
    .count_o (tx_count),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );
  assign tx_valid_o = !tx_empty;
  assign tx_free    = CW'(DEPTH) - tx_count;

  char_irq_gen #(.CW(CW), .THRESH(THRESH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_we_i    (wr_ctrl),
    .en_wdata_i (wdata_i[1:0]),
    .rx_count_i (rx_count),
    .tx_free_i  (tx_free),
    .rx_en_o    (rx_en),
    .tx_en_o    (tx_en),
    .rx_pend_o  (rx_pend),
    .tx_pend_o  (tx_pend),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(addr_i) == REG_DATA) begin
      rdata_o[CHAR_W-1:0]       = rx_empty ? '0 : rx_head;
      rdata_o[VALID_BIT]        = !rx_empty;
      rdata_o[WORD_W-1:FIELD_LSB] = FIELD_W'(rx_count);
    end else begin
      rdata_o[RX_EN_BIT]        = rx_en;
      rdata_o[TX_EN_BIT]        = tx_en;
      rdata_o[RX_PEND_BIT]      = rx_pend;
      rdata_o[TX_PEND_BIT]      = tx_pend;
      rdata_o[WORD_W-1:FIELD_LSB] = FIELD_W'(tx_free);
    end
  end
endmodule

bind char_port_irq char_port_irq_chk #(
  .DEPTH(DEPTH), .CW(CW), .THRESH(THRESH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .rx_count   (rx_count),
  .tx_free    (tx_free),
  .rx_en      (rx_en),
  .tx_en      (tx_en)
);

// File: tb/char_port_irq_bench.sv
`timescale 1ns/1ps
module char_port_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  char_port_irq u_char_port_irq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  function automatic logic [31:0] ctrl_word(int free, bit tp, bit rp, bit te, bit re);
    return {16'(free), 6'b0, tp, rp, 6'b0, te, re};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] c);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1 chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 1);
    bus_read(1'b1, d);
    chk("R1 ctrl", d, ctrl_word(64, 0, 0, 0, 0));
    bus_read(1'b0, d);
    chk("R1 data", d, 32'h0);
  endtask

  task automatic t_rx_threshold;
    logic [31:0] d;
    bus_write(1'b1, 32'h1);
    for (int i = 0; i < 7; i++) rx_push(8'(8'hA0 + i));
    #1 chk("R8 irq at 7", 32'(irq), 0);
    rx_push(8'hA7);
    #1 chk("R8 irq at 8", 32'(irq), 1);
    bus_read(1'b1, d);
    chk("R7 ctrl rx pend", d, ctrl_word(64, 0, 1, 0, 1));
    for (int i = 0; i < 8; i++) begin
      bus_read(1'b0, d);
      chk("R3 data", d, {16'(8 - i), 1'b1, 7'b0, 8'(8'hA0 + i)});
      if (i == 0) #1 chk("R8 irq drops at 7", 32'(irq), 0);
    end
    bus_read(1'b0, d);
    chk("R4 empty read", d, 32'h0);
    bus_read(1'b0, d);
    chk("R4 empty read repeat", d, 32'h0);
    bus_write(1'b1, 32'h0);
  endtask

  task automatic t_rx_full;
    logic [31:0] d;
    for (int i = 0; i < 64; i++) rx_push(8'(i));
    #1 chk("R2 rx_ready full", 32'(rx_ready), 0);
    chk("R10 irq gated full rx", 32'(irq), 0);
    rx_push(8'hEE);
    for (int i = 0; i < 64; i++) begin
      bus_read(1'b0, d);
      if (i == 0 || i == 63) chk("R3 full drain", d, {16'(64 - i), 1'b1, 7'b0, 8'(i)});
      else if (d[7:0] != 8'(i)) chk("R2 order", 32'(d[7:0]), 32'(i));
    end
    bus_read(1'b0, d);
    chk("R2 extra char refused", d, 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    bus_write(1'b1, 32'h2);
    #1 chk("R9 irq free 64", 32'(irq), 1);
    for (int i = 0; i < 56; i++) bus_write(1'b0, 32'(8'h10 + i) | 32'hFF00);
    bus_read(1'b1, d);
    chk("R9 ctrl free 8", d, ctrl_word(8, 1, 0, 1, 0));
    bus_write(1'b0, 32'(8'h10 + 56));
    #1 chk("R9 irq free 7", 32'(irq), 0);
    bus_read(1'b1, d);
    chk("R9 ctrl free 7", d, ctrl_word(7, 0, 0, 1, 0));
    for (int i = 57; i < 64; i++) bus_write(1'b0, 32'(8'h10 + i));
    bus_write(1'b0, 32'hEE);
    bus_read(1'b1, d);
    chk("R6 ctrl free 0", d, ctrl_word(0, 0, 0, 1, 0));
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < 64; i++) begin
      #1;
      if (!tx_valid || tx_data != 8'(8'h10 + i)) begin
        chk("R5 tx order", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'(8'h10 + i)});
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    #1 chk("R6 dropped char absent", 32'(tx_valid), 0);
    chk("R9 irq free 64 again", 32'(irq), 1);
    bus_write(1'b1, 32'h0);
    #1 chk("R10 irq disabled", 32'(irq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rx_threshold();
    t_rx_full();
    t_tx();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule